// File: doc/BRIEF.md
# Link Management Polling Controller

This block runs the link-integrity side of a frame-relay management exchange. A tick-driven poll timer makes it issue status enquiries on its own. Most are keep-alive enquiries. Once a programmable number of keep-alive enquiries has gone out, the next one asks for full status. Each enquiry carries an 8-bit send sequence number. When the peer sends a keep-alive enquiry, the block answers it at once with a keep-alive status frame and restarts a supervision timer. If that timer runs out, the block raises a one-cycle error pulse.

The host handles everything beyond keep-alive. A full-status enquiry from the peer is reported to the host as an indication. The block then holds until the host asks for the full status frame to be sent. Full status frames and asynchronous status frames received from the peer are also reported as indications, and a full status frame first has its echoed sequence number compared with the last one issued. The host can send an asynchronous status frame at any time.

All outgoing frames share one transmit port that carries one frame per cycle. A fixed priority decides which frame goes first. A frame that loses is kept and sent in a later cycle.

The response path is a two-state machine:
- **IDLE**: no host answer is outstanding. A received full-status enquiry takes transition *ENQ_TO_HOLD*.
- **HOLD_FULL**: the block is waiting for the host's full-status send request. That request takes transition *SERVE_TO_IDLE* and queues the full status frame.

Top module: `lmp_link_poll`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_valid`, `ind_valid` and `t2_expired` are low.
- R2: The poll timer counts `tick` pulses. Every `cfg_poll_ticks`-th tick issues one enquiry, and that enquiry appears on the transmit port one cycle after the tick when nothing outranks it.
- R3: Enquiry types are 1 = keep-alive and 2 = full-status. After `cfg_full_every` consecutive keep-alive enquiries, the next enquiry is full-status. Issuing a full-status enquiry restarts that count.
- R4: Every enquiry carries `tx_seq`. The first enquiry after reset has `tx_seq` = 1, each later enquiry adds one, and the value wraps from 255 to 0. For non-enquiry frames `tx_seq` is 0.
- R5: A received type-1 keep-alive enquiry produces a type-3 keep-alive status frame on the transmit port in the next cycle.
- R6: The supervision timer counts ticks and is cleared by each received keep-alive enquiry; a clear in the same cycle as a tick wins over the tick. On the `cfg_t2_ticks`-th tick since the last clear, `t2_expired` pulses for one cycle and the count starts again.
- R7: In IDLE, a received type-2 full-status enquiry gives indication code 13 with parameter 1 and moves the block to HOLD_FULL. In HOLD_FULL, host request code 11 with parameter 0 sends a type-4 full status frame and returns the block to IDLE.
- R8: In HOLD_FULL, further full-status enquiries give no indication. In IDLE, request 11 with parameter 0 sends nothing.
- R9: A received type-5 asynchronous status frame gives indication code 14 with parameter 0.
- R10: A received type-4 full status frame gives indication code 13. The parameter is 0 when `rx_echo_seq` equals the last issued enquiry sequence and 3 otherwise.
- R11: Host request 11 with parameter 2 sends a type-5 asynchronous status frame, whatever the state.
- R12: The transmit port carries at most one frame per cycle. The priority order is keep-alive reply, then full status, then asynchronous status, then enquiry. A frame that loses waits and is sent later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer tick pulse |
| cfg_poll_ticks | input | 8 | Ticks between enquiries |
| cfg_full_every | input | 8 | Keep-alive enquiries before a full-status one (1..255) |
| cfg_t2_ticks | input | 8 | Supervision timeout in ticks |
| rx_valid | input | 1 | A received message is present |
| rx_type | input | 3 | Received message type |
| rx_echo_seq | input | 8 | Sequence number echoed in a received full status frame |
| req_valid | input | 1 | Host request primitive present |
| req_code | input | 4 | Host request code |
| req_param | input | 2 | Host request parameter |
| tx_valid | output | 1 | Frame to send this cycle |
| tx_type | output | 3 | Type of the frame being sent |
| tx_seq | output | 8 | Sequence number of an enquiry |
| ind_valid | output | 1 | Indication primitive to the host |
| ind_code | output | 4 | Indication code |
| ind_param | output | 2 | Indication parameter |
| t2_expired | output | 1 | Supervision timeout pulse |

## Verification
The main collision tested here is a received keep-alive enquiry in the same cycle as the poll timer firing. The bench tracks the poll count and places the peer enquiry on exactly the tick that completes a poll interval. It then expects the keep-alive reply one cycle later and the enquiry one cycle after that, with its sequence number and type unchanged. A second run adds a host full-status send request to that same cycle while the block is in HOLD_FULL. This stacks three frames, and the expected order is reply, full status, enquiry on consecutive cycles.

// File: rtl/lmp_pkg.sv
package lmp_pkg;

    localparam int CNT_W = 8;
    localparam int SEQ_W = 8;

    // message type codes on rx_type / tx_type
    localparam logic [2:0] MSG_NONE       = 3'd0;
    localparam logic [2:0] MSG_ENQ_LIV    = 3'd1;
    localparam logic [2:0] MSG_ENQ_FULL   = 3'd2;
    localparam logic [2:0] MSG_STAT_LIV   = 3'd3;
    localparam logic [2:0] MSG_STAT_FULL  = 3'd4;
    localparam logic [2:0] MSG_STAT_ASYNC = 3'd5;

    // primitive codes
    localparam logic [3:0] PRIM_SEND_STATUS = 4'd11;
    localparam logic [3:0] PRIM_STATUS_EVT  = 4'd13;
    localparam logic [3:0] PRIM_ASYNC_EVT   = 4'd14;

    // primitive parameters
    localparam logic [1:0] PAR_OK        = 2'd0;
    localparam logic [1:0] PAR_FULL_ENQ  = 2'd1;
    localparam logic [1:0] PAR_SEQ_ERR   = 2'd3;
    localparam logic [1:0] PAR_SEND_FULL = 2'd0;
    localparam logic [1:0] PAR_SEND_ASYN = 2'd2;

    // transmit sources, index 0 has highest priority
    localparam int NSRC       = 4;
    localparam int SRC_REPLY  = 0;
    localparam int SRC_FULL   = 1;
    localparam int SRC_ASYNC  = 2;
    localparam int SRC_ENQ    = 3;

    typedef enum logic {
        RSP_IDLE,
        RSP_HOLD_FULL
    } rsp_state_t;

endpackage

// File: rtl/lmp_tick_div.sv
module lmp_tick_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         fire
);
    logic [W-1:0] cnt;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};

    always_comb begin
        fire = tick && !restart && (cnt_inc >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || fire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt_inc[W-1:0];
        end
    end

endmodule

// File: rtl/lmp_poll_gen.sv
module lmp_poll_gen
    import lmp_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int SW = SEQ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [W-1:0]  n_limit,
    output logic          enq_new,
    output logic [2:0]    enq_type,
    output logic [SW-1:0] enq_seq,
    output logic [SW-1:0] last_seq
);
    logic [W-1:0]  liv_cnt;
    logic [SW-1:0] seq_q;
    logic          want_full;

    always_comb begin
        want_full = (liv_cnt >= n_limit);
        enq_new   = fire;
        enq_type  = want_full ? MSG_ENQ_FULL : MSG_ENQ_LIV;
        enq_seq   = seq_q + {{(SW-1){1'b0}}, 1'b1};
        last_seq  = seq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            liv_cnt <= '0;
            seq_q   <= '0;
        end else if (fire) begin
            seq_q   <= enq_seq;
            liv_cnt <= want_full ? '0 : liv_cnt + {{(W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/lmp_rsp_fsm.sv
module lmp_rsp_fsm
    import lmp_pkg::*;
#(
    parameter int SW = SEQ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [2:0]    rx_type,
    input  logic [SW-1:0] rx_echo_seq,
    input  logic [SW-1:0] last_seq,
    input  logic          req_valid,
    input  logic [3:0]    req_code,
    input  logic [1:0]    req_param,
    output logic          new_reply,
    output logic          new_full,
    output logic          new_async,
    output logic          t2_restart,
    output logic          ind_valid,
    output logic [3:0]    ind_code,
    output logic [1:0]    ind_param
);
    rsp_state_t state, state_nx;

    logic rx_liv_enq, rx_full_enq, rx_full_stat, rx_async_stat;
    logic host_full, host_async;
    logic       ind_v_nx;
    logic [3:0] ind_c_nx;
    logic [1:0] ind_p_nx;

    always_comb begin
        rx_liv_enq    = rx_valid && (rx_type == MSG_ENQ_LIV);
        rx_full_enq   = rx_valid && (rx_type == MSG_ENQ_FULL);
        rx_full_stat  = rx_valid && (rx_type == MSG_STAT_FULL);
        rx_async_stat = rx_valid && (rx_type == MSG_STAT_ASYNC);
        host_full     = req_valid && (req_code == PRIM_SEND_STATUS) && (req_param == PAR_SEND_FULL);
        host_async    = req_valid && (req_code == PRIM_SEND_STATUS) && (req_param == PAR_SEND_ASYN);
    end

    // transitions and transmit requests
    always_comb begin
        state_nx   = state;
        new_full   = 1'b0;
        new_reply  = rx_liv_enq;
        t2_restart = rx_liv_enq;
        new_async  = host_async;
        unique case (state)
            RSP_IDLE: begin
                if (rx_full_enq) state_nx = RSP_HOLD_FULL;      // ENQ_TO_HOLD
            end
            RSP_HOLD_FULL: begin
                if (host_full) begin                            // SERVE_TO_IDLE
                    state_nx = RSP_IDLE;
                    new_full = 1'b1;
                end
            end
        endcase
    end

    // indication selection
    always_comb begin
        ind_v_nx = 1'b0;
        ind_c_nx = 4'd0;
        ind_p_nx = 2'd0;
        if (rx_full_enq && (state == RSP_IDLE)) begin
            ind_v_nx = 1'b1;
            ind_c_nx = PRIM_STATUS_EVT;
            ind_p_nx = PAR_FULL_ENQ;
        end else if (rx_full_stat) begin
            ind_v_nx = 1'b1;
            ind_c_nx = PRIM_STATUS_EVT;
            ind_p_nx = (rx_echo_seq == last_seq) ? PAR_OK : PAR_SEQ_ERR;
        end else if (rx_async_stat) begin
            ind_v_nx = 1'b1;
            ind_c_nx = PRIM_ASYNC_EVT;
            ind_p_nx = PAR_OK;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= state_nx;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ind_valid <= 1'b0;
            ind_code  <= 4'd0;
            ind_param <= 2'd0;
        end else begin
            ind_valid <= ind_v_nx;
            ind_code  <= ind_c_nx;
            ind_param <= ind_p_nx;
        end
    end

    AST_HOLD_NO_REIND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RSP_HOLD_FULL && rx_valid && rx_type == MSG_ENQ_FULL)
        |=> !(ind_valid && ind_code == PRIM_STATUS_EVT && ind_param == PAR_FULL_ENQ)); // R8

    AST_IND_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ind_valid |-> (ind_code == PRIM_STATUS_EVT || ind_code == PRIM_ASYNC_EVT)); // R7

endmodule

// File: rtl/lmp_tx_arb.sv
module lmp_tx_arb
    import lmp_pkg::*;
#(
    parameter int SW = SEQ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          new_reply,
    input  logic          new_full,
    input  logic          new_async,
    input  logic          new_enq,
    input  logic [2:0]    enq_type,
    input  logic [SW-1:0] enq_seq,
    output logic          tx_valid,
    output logic [2:0]    tx_type,
    output logic [SW-1:0] tx_seq
);
    logic [NSRC-1:0] pend, fresh, want, grant;
    logic [2:0]      p_enq_type, cur_enq_type;
    logic [SW-1:0]   p_enq_seq, cur_enq_seq;
    logic [2:0]      sel_type;
    logic [SW-1:0]   sel_seq;

    always_comb begin
        fresh            = '0;
        fresh[SRC_REPLY] = new_reply;
        fresh[SRC_FULL]  = new_full;
        fresh[SRC_ASYNC] = new_async;
        fresh[SRC_ENQ]   = new_enq;
        want             = pend | fresh;
        cur_enq_type     = new_enq ? enq_type : p_enq_type;
        cur_enq_seq      = new_enq ? enq_seq  : p_enq_seq;
    end

    // fixed priority, lowest index first
    always_comb begin
        grant = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (want[i] && (grant == '0)) grant[i] = 1'b1;
        end
    end

    always_comb begin
        sel_type = MSG_NONE;
        sel_seq  = '0;
        unique case (1'b1)
            grant[SRC_REPLY]: sel_type = MSG_STAT_LIV;
            grant[SRC_FULL]:  sel_type = MSG_STAT_FULL;
            grant[SRC_ASYNC]: sel_type = MSG_STAT_ASYNC;
            grant[SRC_ENQ]: begin
                sel_type = cur_enq_type;
                sel_seq  = cur_enq_seq;
            end
            default: sel_type = MSG_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend       <= '0;
            p_enq_type <= MSG_NONE;
            p_enq_seq  <= '0;
            tx_valid   <= 1'b0;
            tx_type    <= MSG_NONE;
            tx_seq     <= '0;
        end else begin
            pend     <= want & ~grant;
            tx_valid <= (grant != '0);
            tx_type  <= sel_type;
            tx_seq   <= sel_seq;
            if (new_enq) begin
                p_enq_type <= enq_type;
                p_enq_seq  <= enq_seq;
            end
        end
    end

    AST_ENQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (new_enq && (new_reply || new_full || new_async)) |=> pend[SRC_ENQ]); // R12

    AST_TX_TYPED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_type != MSG_NONE)); // R12

endmodule

// File: rtl/lmp_link_poll.sv
module lmp_link_poll
    import lmp_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEQ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cfg_poll_ticks,
    input  logic [CW-1:0] cfg_full_every,
    input  logic [CW-1:0] cfg_t2_ticks,
    input  logic          rx_valid,
    input  logic [2:0]    rx_type,
    input  logic [SW-1:0] rx_echo_seq,
    input  logic          req_valid,
    input  logic [3:0]    req_code,
    input  logic [1:0]    req_param,
    output logic          tx_valid,
    output logic [2:0]    tx_type,
    output logic [SW-1:0] tx_seq,
    output logic          ind_valid,
    output logic [3:0]    ind_code,
    output logic [1:0]    ind_param,
    output logic          t2_expired
);
    logic          poll_fire, t2_fire, t2_restart;
    logic          enq_new, new_reply, new_full, new_async;
    logic [2:0]    enq_type;
    logic [SW-1:0] enq_seq, last_seq;

    lmp_tick_div #(.W(CW)) u_poll_div (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(1'b0),
        .limit(cfg_poll_ticks), .fire(poll_fire)
    );

    lmp_tick_div #(.W(CW)) u_t2_div (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(t2_restart),
        .limit(cfg_t2_ticks), .fire(t2_fire)
    );

    lmp_poll_gen #(.W(CW), .SW(SW)) u_poll (
        .clk(clk), .rst_n(rst_n), .fire(poll_fire), .n_limit(cfg_full_every),
        .enq_new(enq_new), .enq_type(enq_type), .enq_seq(enq_seq), .last_seq(last_seq)
    );

    lmp_rsp_fsm #(.SW(SW)) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_type(rx_type), .rx_echo_seq(rx_echo_seq),
        .last_seq(last_seq),
        .req_valid(req_valid), .req_code(req_code), .req_param(req_param),
        .new_reply(new_reply), .new_full(new_full), .new_async(new_async),
        .t2_restart(t2_restart),
        .ind_valid(ind_valid), .ind_code(ind_code), .ind_param(ind_param)
    );

    lmp_tx_arb #(.SW(SW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .new_reply(new_reply), .new_full(new_full), .new_async(new_async),
        .new_enq(enq_new), .enq_type(enq_type), .enq_seq(enq_seq),
        .tx_valid(tx_valid), .tx_type(tx_type), .tx_seq(tx_seq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t2_expired <= 1'b0;
        else        t2_expired <= t2_fire;
    end

    AST_LIV_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_type == MSG_ENQ_LIV) |=> (tx_valid && tx_type == MSG_STAT_LIV)); // R5

    AST_T2_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_type == MSG_ENQ_LIV) |=> !t2_expired); // R6

endmodule

// File: tb/test_lmp_link_poll.sv
`timescale 1ns/1ps
module test_lmp_link_poll;
    import lmp_pkg::*;

    localparam int P = 3;
    localparam int N = 2;
    localparam int T = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cfg_poll_ticks = 8'(P);
    logic [7:0] cfg_full_every = 8'(N);
    logic [7:0] cfg_t2_ticks = 8'(T);
    logic       rx_valid = 1'b0;
    logic [2:0] rx_type = 3'd0;
    logic [7:0] rx_echo_seq = 8'd0;
    logic       req_valid = 1'b0;
    logic [3:0] req_code = 4'd0;
    logic [1:0] req_param = 2'd0;
    logic       tx_valid, ind_valid, t2_expired;
    logic [2:0] tx_type;
    logic [7:0] tx_seq;
    logic [3:0] ind_code;
    logic [1:0] ind_param;

    always #2 clk = ~clk;

    lmp_link_poll i_lmp_link_poll (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_poll_ticks(cfg_poll_ticks), .cfg_full_every(cfg_full_every),
        .cfg_t2_ticks(cfg_t2_ticks),
        .rx_valid(rx_valid), .rx_type(rx_type), .rx_echo_seq(rx_echo_seq),
        .req_valid(req_valid), .req_code(req_code), .req_param(req_param),
        .tx_valid(tx_valid), .tx_type(tx_type), .tx_seq(tx_seq),
        .ind_valid(ind_valid), .ind_code(ind_code), .ind_param(ind_param),
        .t2_expired(t2_expired)
    );

    typedef struct { int cyc; logic [2:0] typ; logic [7:0] seq; string rq; } tx_item_t;
    typedef struct { int cyc; logic [3:0] code; logic [1:0] par; string rq; } ind_item_t;

    tx_item_t  txq[$];
    ind_item_t indq[$];
    int        expq[$];
    int        cyc = 0;
    int        n_cmp = 0;
    int        n_bad = 0;
    bit        running = 0;
    bit        done = 0;

    // reference model state
    int         m_pc = 0, m_k = 0, m_t2 = 0, m_seq = 0;
    bit         m_hold = 0;
    bit         pr = 0, pf = 0, pa = 0, pe = 0;
    logic [2:0] pe_typ = 3'd0;
    logic [7:0] pe_seq = 8'd0;

    always @(posedge clk) cyc <= cyc + 1;

    // driver: applies one cycle of stimulus and pushes what must come out
    task automatic step(input bit tk, input logic [2:0] rt, input logic [7:0] echo,
                        input bit rq, input logic [3:0] code, input logic [1:0] par);
        bit         nr, nf, na, ne;
        logic [2:0] etyp;
        tx_item_t   ti;
        ind_item_t  ii;
        @(negedge clk);
        tick = tk; rx_valid = (rt != MSG_NONE); rx_type = rt; rx_echo_seq = echo;
        req_valid = rq; req_code = code; req_param = par;
        nr = (rt == MSG_ENQ_LIV);
        nf = 0; na = 0; ne = 0; etyp = MSG_NONE;
        // supervision timer (R6)
        if (nr) m_t2 = 0;
        else if (tk) begin
            if (m_t2 + 1 >= T) begin m_t2 = 0; expq.push_back(cyc + 1); end
            else m_t2++;
        end
        // poll timer (R2, R3, R4)
        if (tk) begin
            if (m_pc + 1 >= P) begin
                m_pc = 0; ne = 1;
                m_seq = (m_seq + 1) % 256;
                if (m_k >= N) begin etyp = MSG_ENQ_FULL; m_k = 0; end
                else begin etyp = MSG_ENQ_LIV; m_k++; end
            end else m_pc++;
        end
        // host / indications
        if (rq && code == 4'd11 && par == 2'd2) na = 1;                     // R11
        ii.cyc = cyc + 1;
        if (rt == MSG_ENQ_FULL && !m_hold) begin
            ii.code = 4'd13; ii.par = 2'd1; ii.rq = "R7"; indq.push_back(ii);
        end else if (rt == MSG_STAT_FULL) begin
            ii.code = 4'd13; ii.par = (echo == 8'(m_seq)) ? 2'd0 : 2'd3; ii.rq = "R10";
            indq.push_back(ii);
        end else if (rt == MSG_STAT_ASYNC) begin
            ii.code = 4'd14; ii.par = 2'd0; ii.rq = "R9"; indq.push_back(ii);
        end
        if (m_hold) begin
            if (rq && code == 4'd11 && par == 2'd0) begin nf = 1; m_hold = 0; end
        end else if (rt == MSG_ENQ_FULL) m_hold = 1;
        // priority model (R12)
        if (ne) begin pe_typ = etyp; pe_seq = 8'(m_seq); end
        ti.cyc = cyc + 1; ti.seq = 8'd0;
        if (pr || nr) begin
            ti.typ = MSG_STAT_LIV; ti.rq = pr ? "R12" : "R5"; pr = 0; nr = 0; txq.push_back(ti);
        end else if (pf || nf) begin
            ti.typ = MSG_STAT_FULL; ti.rq = pf ? "R12" : "R7"; pf = 0; nf = 0; txq.push_back(ti);
        end else if (pa || na) begin
            ti.typ = MSG_STAT_ASYNC; ti.rq = pa ? "R12" : "R11"; pa = 0; na = 0; txq.push_back(ti);
        end else if (pe || ne) begin
            ti.typ = pe_typ; ti.seq = pe_seq; ti.rq = pe ? "R12" : "R2 R3 R4";
            pe = 0; ne = 0; txq.push_back(ti);
        end
        pr = pr | nr; pf = pf | nf; pa = pa | na; pe = pe | ne;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, MSG_NONE, 8'd0, 0, 4'd0, 2'd0);
    endtask

    task automatic quiet(input string r);
        @(posedge clk); #1;
        n_cmp++;
        if (ind_valid || tx_valid) begin
            n_bad++;
            $display("FAIL %s ignored stimulus: ind_valid=%0b tx_valid=%0b expected 0/0",
                     r, ind_valid, tx_valid);
        end
    endtask

    // monitor: compares outputs with the expected queues
    always @(negedge clk) begin
        if (running) begin
            while (txq.size() > 0 && txq[0].cyc < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL %s missing tx: got none expected type %0d", txq[0].rq, txq[0].typ);
                void'(txq.pop_front());
            end
            if (tx_valid) begin
                n_cmp++;
                if (txq.size() == 0 || txq[0].cyc != cyc) begin
                    n_bad++;
                    $display("FAIL R8 unexpected tx: got type %0d expected none", tx_type);
                end else begin
                    if (tx_type != txq[0].typ || tx_seq != txq[0].seq) begin
                        n_bad++;
                        $display("FAIL %s tx: got type %0d seq %0d expected type %0d seq %0d",
                                 txq[0].rq, tx_type, tx_seq, txq[0].typ, txq[0].seq);
                    end
                    void'(txq.pop_front());
                end
            end
            while (indq.size() > 0 && indq[0].cyc < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL %s missing ind: got none expected code %0d", indq[0].rq, indq[0].code);
                void'(indq.pop_front());
            end
            if (ind_valid) begin
                n_cmp++;
                if (indq.size() == 0 || indq[0].cyc != cyc) begin
                    n_bad++;
                    $display("FAIL R8 unexpected ind: got code %0d par %0d expected none",
                             ind_code, ind_param);
                end else begin
                    if (ind_code != indq[0].code || ind_param != indq[0].par) begin
                        n_bad++;
                        $display("FAIL %s ind: got %0d/%0d expected %0d/%0d", indq[0].rq,
                                 ind_code, ind_param, indq[0].code, indq[0].par);
                    end
                    void'(indq.pop_front());
                end
            end
            while (expq.size() > 0 && expq[0] < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL R6 missing t2_expired: got 0 expected 1");
                void'(expq.pop_front());
            end
            if (t2_expired) begin
                n_cmp++;
                if (expq.size() == 0 || expq[0] != cyc) begin
                    n_bad++;
                    $display("FAIL R6 t2_expired: got 1 expected 0");
                end else void'(expq.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;                                                              // R1
        if (tx_valid || ind_valid || t2_expired) begin
            n_bad++;
            $display("FAIL R1 in reset: got %0b%0b%0b expected 000", tx_valid, ind_valid, t2_expired);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;                                                              // R1
        if (tx_valid || ind_valid || t2_expired) begin
            n_bad++;
            $display("FAIL R1 after reset: got %0b%0b%0b expected 000", tx_valid, ind_valid, t2_expired);
        end
        running = 1;

        // R2 R3 R6: plain polling with ticks spaced out
        for (int i = 0; i < 14; i++) begin
            step(1, MSG_NONE, 8'd0, 0, 4'd0, 2'd0);
            idle(1);
        end
        // R5: peer keep-alive enquiry
        step(0, MSG_ENQ_LIV, 8'd0, 0, 4'd0, 2'd0); idle(2);
        // R7 R8: full-status enquiry, repeated, then served
        step(0, MSG_ENQ_FULL, 8'd0, 0, 4'd0, 2'd0); idle(1);
        step(0, MSG_ENQ_FULL, 8'd0, 0, 4'd0, 2'd0); quiet("R8");
        step(0, MSG_NONE, 8'd0, 1, 4'd11, 2'd0); idle(2);
        step(0, MSG_NONE, 8'd0, 1, 4'd11, 2'd0); quiet("R8");
        // R11 R9
        step(0, MSG_NONE, 8'd0, 1, 4'd11, 2'd2); idle(1);
        step(0, MSG_STAT_ASYNC, 8'd0, 0, 4'd0, 2'd0); idle(1);
        // R10: good and bad echoed sequence
        step(0, MSG_STAT_FULL, 8'(m_seq), 0, 4'd0, 2'd0); idle(1);
        step(0, MSG_STAT_FULL, 8'(m_seq + 7), 0, 4'd0, 2'd0); idle(1);
        // R12: keep-alive reply and poll enquiry collide
        while (m_pc + 1 < P) step(1, MSG_NONE, 8'd0, 0, 4'd0, 2'd0);
        step(1, MSG_ENQ_LIV, 8'd0, 0, 4'd0, 2'd0); idle(3);
        // R12: reply, full status and enquiry collide
        step(0, MSG_ENQ_FULL, 8'd0, 0, 4'd0, 2'd0); idle(1);
        while (m_pc + 1 < P) step(1, MSG_NONE, 8'd0, 0, 4'd0, 2'd0);
        step(1, MSG_ENQ_LIV, 8'd0, 1, 4'd11, 2'd0); idle(4);
        // R12: async request and enquiry collide
        while (m_pc + 1 < P) step(1, MSG_NONE, 8'd0, 0, 4'd0, 2'd0);
        step(1, MSG_NONE, 8'd0, 1, 4'd11, 2'd2); idle(3);
        // R4: back-to-back ticks until the sequence wraps, R6 with short timeout
        for (int i = 0; i < 800; i++) step(1, MSG_NONE, 8'd0, 0, 4'd0, 2'd0);
        idle(4);

        running = 0;
        n_cmp++;
        if (txq.size() != 0 || indq.size() != 0 || expq.size() != 0) begin
            n_bad++;
            $display("FAIL R12 leftover expected items: got %0d/%0d/%0d expected 0/0/0",
                     txq.size(), indq.size(), expq.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule